// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block gates a group of clock outputs derived from one free-running source clock. An active-low stop request may arrive at any time with no relation to the clock. It is first brought into the source clock domain. The gated outputs then fall silent in the low state. When the request is withdrawn, they start again, and every high pulse is whole. The request is honoured only while the mode strap, captured during reset, selects the low-power (mobile) setting. Members of the group marked as free-running ignore the request. A per-output enable bit from configuration can silence any member on its own.

A restart opens a minimum run window. A stop request that arrives inside the window waits and takes effect when the window closes. The synchronizer depth and the window length are parameters. One design therefore covers a processor-style group (long window, a few cycles of latency) and a bus-style group (short window, short synchronizer).

Top module: `clk_stop_gate`

## Requirements
- R1: The stop request passes through SYNC_STAGES flops on the rising source edge. Number source rising edges from 0, the edge just before the request falls. The gated outputs still pulse high on edges 1 through SYNC_STAGES+1 and carry no high pulse from edge SYNC_STAGES+2 on.
- R2: A stopped gated output rests at 0. No output is ever high while the source clock is low.
- R3: Every high pulse on a gated output starts at a rising source edge and lasts a full half period of the source, so no runt pulse appears.
- R4: Number the edges from 0 at the edge just before the request rises. After the release the first high pulse appears on edge SYNC_STAGES+2, and edges 1 through SYNC_STAGES+1 carry none.
- R5: After a restart the outputs give at least MIN_RUN_CYC high pulses before any stop can take effect.
- R6: A stop request that arrives during the minimum run window is held pending. The outputs give exactly MIN_RUN_CYC pulses, starting at the first pulse of R4, and stop on the next edge.
- R7: The mode strap is captured while rst is high. A captured 1 makes the stop request have no effect. A strap change after reset has no effect.
- R8: An output whose bit in FREE_MASK is 1 keeps pulsing while the group is stopped.
- R9: An output whose out_en bit is 0 stays low from the first rising edge after the bit is cleared, whatever the stop request does. Setting the bit again restores pulses on the next rising edge.
- R10: While rst is high all outputs are low. On the first rising edge after rst falls, every enabled output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running source clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| mode_strap | input | 1 | Mode strap, captured during reset (0 = stop honoured) |
| out_en | input | N_OUT | Per-output enable from configuration |
| clk_out | output | N_OUT | Gated clock outputs |

## Verification
The bench builds the block with four outputs, the top one free-running, a two-stage synchronizer and a 12-cycle minimum run window. With these values the whole run window and both latency edges fit in a short cycle-by-cycle sweep. The bench compares every sampled high phase against edge numbers derived from the requirements. It runs the pending-stop case with the release held for one cycle and for three cycles, and it checks the strap both when captured and when changed after reset.

// File: rtl/clk_stop_gate_pkg.sv
package clk_stop_gate_pkg;

    typedef enum logic [1:0] {
        GS_FREE = 2'd0,
        GS_HOLD = 2'd1,
        GS_STOP = 2'd2
    } gate_state_e;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q[s] <= 1'b1;
                end else if (s == 0) begin
                    chain_q[s] <= d_async;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/csg_run_ctrl.sv
module csg_run_ctrl
    import clk_stop_gate_pkg::*;
#(
    parameter int unsigned MIN_RUN_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_sync_n,
    input  logic honour_stop,
    output logic run
);
    localparam int unsigned CW = cnt_width(MIN_RUN_CYC);
    localparam logic [CW-1:0] LOAD_VAL = CW'(MIN_RUN_CYC - 1);
    localparam logic [CW-1:0] AGE_MAX  = CW'(MIN_RUN_CYC);

    gate_state_e   state_q;
    logic [CW-1:0] cnt_q;
    logic          stop_want;

    assign stop_want = !stop_sync_n && honour_stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GS_FREE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                GS_FREE: if (stop_want) state_q <= GS_STOP;
                GS_STOP: if (!stop_want) begin
                    state_q <= GS_HOLD;
                    cnt_q   <= LOAD_VAL;
                end
                GS_HOLD: begin
                    if (cnt_q == '0) begin
                        state_q <= stop_want ? GS_STOP : GS_FREE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= GS_FREE;
            endcase
        end
    end

    assign run = (state_q != GS_STOP);

    // running-age tracker used only by the checks below
    logic [CW-1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= AGE_MAX;
        end else if (state_q == GS_STOP) begin
            age_q <= '0;
        end else if (age_q != AGE_MAX) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R5: a stop never lands before the full run window has elapsed
    p_min_run_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == GS_STOP) |-> (age_q == AGE_MAX));

    // R5: leaving the stopped state always opens a run window
    p_stop_exits_to_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(state_q) == GS_STOP && state_q != GS_STOP)
        |-> (state_q == GS_HOLD));

    // R7: with the strap set the group is never stopped
    p_strap_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(honour_stop)) |-> (state_q != GS_STOP));
endmodule

// File: rtl/csg_gate_cell.sv
module csg_gate_cell #(
    parameter bit FREE_RUN = 1'b0
) (
    input  logic clk_src,
    input  logic rst,
    input  logic run_i,
    input  logic cfg_en_i,
    output logic clk_o
);
    logic en_q;

    always_ff @(negedge clk_src) begin
        if (rst) begin
            en_q <= 1'b0;
        end else begin
            en_q <= (run_i || FREE_RUN) && cfg_en_i;
        end
    end

    assign clk_o = clk_src & en_q;

    // R9: a cleared enable keeps the high phase silent
    p_disabled_low_r9: assert property (@(negedge clk_src) disable iff (rst)
        (!$past(rst) && !$past(cfg_en_i)) |-> !clk_o);

    generate
        if (FREE_RUN) begin : g_free_chk
            // R8: a free member pulses whenever it is enabled
            p_free_member_r8: assert property (@(negedge clk_src) disable iff (rst)
                (!$past(rst) && $past(cfg_en_i)) |-> clk_o);
        end
    endgenerate
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
    parameter int unsigned        N_OUT       = 3,
    parameter int unsigned        SYNC_STAGES = 2,
    parameter int unsigned        MIN_RUN_CYC = 100,
    parameter logic [N_OUT-1:0]   FREE_MASK   = '0
) (
    input  logic             clk_src,
    input  logic             rst,
    input  logic             stop_req_n,
    input  logic             mode_strap,
    input  logic [N_OUT-1:0] out_en,
    output logic [N_OUT-1:0] clk_out
);
    logic strap_q;
    logic stop_sync_n;
    logic run;

    always_ff @(posedge clk_src) begin
        if (rst) begin
            strap_q <= mode_strap;
        end
    end

    csg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_src),
        .rst     (rst),
        .d_async (stop_req_n),
        .q_sync  (stop_sync_n)
    );

    csg_run_ctrl #(.MIN_RUN_CYC(MIN_RUN_CYC)) u_ctrl (
        .clk         (clk_src),
        .rst         (rst),
        .stop_sync_n (stop_sync_n),
        .honour_stop (!strap_q),
        .run         (run)
    );

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_out
            csg_gate_cell #(.FREE_RUN(FREE_MASK[i])) u_cell (
                .clk_src  (clk_src),
                .rst      (rst),
                .run_i    (run),
                .cfg_en_i (out_en[i]),
                .clk_o    (clk_out[i])
            );
        end
    endgenerate
endmodule

// File: tb/clk_stop_gate_tb_top.sv
`timescale 1ns/100ps
module clk_stop_gate_tb_top;
    localparam int unsigned N   = 4;
    localparam int unsigned SYN = 2;
    localparam int unsigned MR  = 12;
    localparam logic [N-1:0] FM = 4'b1000;
    localparam int unsigned LAT = SYN + 2;

    logic         clk_src = 1'b0;
    logic         rst = 1'b1;
    logic         stop_req_n = 1'b1;
    logic         mode_strap = 1'b0;
    logic [N-1:0] out_en = 4'b1111;
    logic [N-1:0] clk_out;

    int errors = 0;
    int checks = 0;
    int width_err = 0;
    int lowph_err = 0;
    bit done = 0;

    always #2 clk_src = ~clk_src;

    clk_stop_gate #(.N_OUT(N), .SYNC_STAGES(SYN), .MIN_RUN_CYC(MR), .FREE_MASK(FM)) dut_i (
        .clk_src(clk_src), .rst(rst), .stop_req_n(stop_req_n),
        .mode_strap(mode_strap), .out_en(out_en), .clk_out(clk_out)
    );

    generate
        for (genvar g = 0; g < N; g++) begin : g_mon
            realtime t_up = 0.0;
            always @(posedge clk_out[g]) begin
                t_up = $realtime;
                if (clk_src !== 1'b1) width_err++;
            end
            always @(negedge clk_out[g]) begin
                if ($realtime - t_up != 2.0) width_err++;
            end
        end
    endgenerate

    always @(negedge clk_src) begin
        #0.5;
        if (!rst && clk_out !== '0) lowph_err++;
    end

    task automatic tick();
        @(posedge clk_src);
        #1;
    endtask

    task automatic chk(input logic [N-1:0] exp, input string tag);
        checks++;
        if (clk_out !== exp) begin
            errors++;
            $display("FAIL %s: clk_out=%b expected=%b at %0t", tag, clk_out, exp, $time);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1;
        mode_strap = strap;
        stop_req_n = 1'b1;
        repeat (4) tick();
        rst = 1'b0;
        tick();
        mode_strap = 1'b0;
    endtask

    // release the request, re-assert it after hold_t cycles, sweep the run window
    task automatic restart_sweep(input int hold_t);
        stop_req_n = 1'b1;
        for (int k = 1; k <= int'(MR + LAT + 4); k++) begin
            tick();
            if (k == hold_t) stop_req_n = 1'b0;
            if (k < int'(LAT))
                chk(4'b1000, "R4 off before on-latency");
            else if (k < int'(LAT + MR))
                chk(4'b1111, (k == int'(LAT)) ? "R4 first pulse" : "R5 run window");
            else
                chk(4'b1000, (k == int'(LAT + MR)) ? "R6 pending stop at expiry" : "R6 stays stopped");
        end
    endtask

    initial begin
        repeat (2) tick();
        chk(4'b0000, "R10 low in reset");
        rst = 1'b0;
        tick();
        chk(4'b1111, "R10 first pulse after reset");

        // off latency from the free state
        repeat (5) tick();
        stop_req_n = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            tick();
            if (k <= int'(SYN + 1)) chk(4'b1111, "R1 pulses inside off-latency");
            else chk(4'b1000, "R1 stopped / R8 free member runs");
        end
        repeat (10) tick();
        chk(4'b1000, "R2 rests low while stopped");

        restart_sweep(1);
        repeat (6) tick();
        restart_sweep(3);

        // long release, then a stop outside the window
        stop_req_n = 1'b1;
        repeat (MR + 10) tick();
        chk(4'b1111, "R4 running after long release");
        stop_req_n = 1'b0;
        for (int k = 1; k <= int'(LAT); k++) begin
            tick();
            if (k < int'(LAT)) chk(4'b1111, "R1 latency after window");
            else chk(4'b1000, "R1 stop after window");
        end

        // enables while stopped and while running
        out_en = 4'b0111;
        tick();
        chk(4'b0000, "R9 free member disabled");
        out_en = 4'b1111;
        stop_req_n = 1'b1;
        repeat (MR + 8) tick();
        out_en = 4'b1101;
        tick();
        chk(4'b1101, "R9 disabled bit low at once");
        stop_req_n = 1'b0;
        repeat (8) tick();
        chk(4'b1000, "R9 disabled bit low while stopped");
        out_en = 4'b1111;
        stop_req_n = 1'b1;
        repeat (MR + 8) tick();
        chk(4'b1111, "R9 re-enabled bit pulses");

        // strap captured as 1: stop ignored
        do_reset(1'b1);
        stop_req_n = 1'b0;
        begin
            int bad = 0;
            for (int k = 0; k < 30; k++) begin
                tick();
                if (clk_out !== 4'b1111) bad++;
            end
            checks++;
            if (bad != 0) begin
                errors++;
                $display("FAIL R7 strap=1 stop ignored: mismatches=%0d expected=0", bad);
            end
        end

        // strap captured as 0, then raised after reset: stop still honoured
        do_reset(1'b0);
        mode_strap = 1'b1;
        tick();
        stop_req_n = 1'b0;
        repeat (LAT) tick();
        chk(4'b1000, "R7 late strap change ignored");

        checks++;
        if (width_err != 0) begin
            errors++;
            $display("FAIL R3 pulse shape: bad_pulses=%0d expected=0", width_err);
        end
        checks++;
        if (lowph_err != 0) begin
            errors++;
            $display("FAIL R2 low phase: high_samples=%0d expected=0", lowph_err);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule